// File: doc/BRIEF.md
# Register File with Byte ALU and Flag Register

This block holds the sixteen 8-bit general registers of a small CPU and executes the instructions that write them from register or immediate operands. These are the immediate load, the immediate add, and the register-to-register group of copy, bitwise logic, add, two subtract orderings and single-bit shifts. The top register, vF, doubles as the flag register. Arithmetic and shift operations write their carry, not-borrow or shifted-out bit into it.

The instruction decoder presents the high opcode nibble (class), the low nibble (sub-operation), the X and Y register indices, the immediate byte and a compatibility-mode bit, qualified by a valid strobe. The block reads vX and vY combinationally and computes the result and the flag from those values. It shows the write enables and write data for vX and for vF on its outputs and commits both at the next rising clock edge. When X selects vF and the operation also writes the flag, the flag value is what lands in vF.

Top module: `byte_alu_regs`

## Requirements
- R1: With class 6 and valid high, vX is written with the immediate byte and vF is not written.
- R2: With class 7, vX is written with (vX + immediate) mod 256. vF is not written and holds its value, even when the sum wraps.
- R3: With class 8, sub-operation 0 writes vY to vX, and sub-operations 1, 2 and 3 write vX OR vY, vX AND vY and vX XOR vY to vX.
- R4: For class 8, sub-operations 0 to 3 write 0 to vF when the compatibility bit is 1. They leave vF unwritten when the bit is 0.
- R5: Class 8, sub-operation 4 writes (vX + vY) mod 256 to vX and writes the carry-out (1 when the sum exceeds 255, else 0) to vF.
- R6: Class 8, sub-operation 5 writes (vX − vY) mod 256 to vX and writes 1 to vF when vX ≥ vY, else 0.
- R7: Class 8, sub-operation 7 writes (vY − vX) mod 256 to vX and writes 1 to vF when vY ≥ vX, else 0.
- R8: Class 8, sub-operation 6 writes vX shifted right by one to vX and old bit 0 to vF. Sub-operation 0xE writes vX shifted left by one (mod 256) to vX and old bit 7 to vF.
- R9: When X is 0xF and the operation writes both the result and the flag, vF holds the flag value after the edge.
- R10: x_val_o and y_val_o show the stored vX and vY in the same cycle. Results and flags are computed from those pre-write values and take effect at the next rising edge.
- R11: When valid is low, or the class is not 6, 7 or 8, or a class 8 sub-operation is not 0 to 7 or 0xE, both write enables are low and no register changes.
- R12: Asynchronous reset clears all sixteen registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_class_i | input | 4 | High opcode nibble (6, 7 or 8 act) |
| op_sub_i | input | 4 | Low opcode nibble, class 8 sub-operation |
| x_idx_i | input | 4 | Destination / first operand index |
| y_idx_i | input | 4 | Second operand index |
| imm_i | input | 8 | Immediate byte |
| compat_i | input | 1 | Compatibility mode: logic ops clear vF |
| x_val_o | output | 8 | Current value of vX |
| y_val_o | output | 8 | Current value of vY |
| vx_we_o | output | 1 | Result write to vX this cycle |
| vx_wdata_o | output | 8 | Result data for vX |
| vf_we_o | output | 1 | Flag write to vF this cycle |
| vf_wdata_o | output | 8 | Flag data for vF (0 or 1) |

## Verification
The bench builds the block at its default of 8-bit data and sixteen registers. At that size every carry, borrow and shift-out boundary (0xFF + 0x01, 0x00 − 0x01, bit 7 and bit 0) is reachable with single immediate loads. Register index 0xF is also hit often by random X and Y values, which puts the flag-over-result priority and vF used as an operand within reach. Directed sequences cover equal-operand subtraction, both compatibility settings and undefined sub-operations. A long random run then mixes every class, including invalid ones, against the bench model.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] CLS_LDI = 4'h6;
  localparam logic [NIB_W-1:0] CLS_ADI = 4'h7;
  localparam logic [NIB_W-1:0] CLS_RR  = 4'h8;

  localparam logic [NIB_W-1:0] SUB_MOV  = 4'h0;
  localparam logic [NIB_W-1:0] SUB_OR   = 4'h1;
  localparam logic [NIB_W-1:0] SUB_AND  = 4'h2;
  localparam logic [NIB_W-1:0] SUB_XOR  = 4'h3;
  localparam logic [NIB_W-1:0] SUB_ADD  = 4'h4;
  localparam logic [NIB_W-1:0] SUB_SUB  = 4'h5;
  localparam logic [NIB_W-1:0] SUB_SHR  = 4'h6;
  localparam logic [NIB_W-1:0] SUB_RSUB = 4'h7;
  localparam logic [NIB_W-1:0] SUB_SHL  = 4'hE;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_LDI,
    OP_ADI,
    OP_MOV,
    OP_OR,
    OP_AND,
    OP_XOR,
    OP_ADD,
    OP_SUB,
    OP_RSUB,
    OP_SHR,
    OP_SHL
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    res_we;
    logic    flag_we;
    logic    flag_clr;   // flag forced to zero (compat logic ops)
  } alu_ctrl_t;

endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
  import byte_alu_pkg::*;
(
  input  logic             valid_i,
  input  logic [NIB_W-1:0] class_i,
  input  logic [NIB_W-1:0] sub_i,
  input  logic             compat_i,
  output alu_ctrl_t        ctrl_o
);

  alu_op_e op;

  always_comb begin
    op = OP_NONE;
    if (valid_i) begin
      unique case (class_i)
        CLS_LDI: op = OP_LDI;
        CLS_ADI: op = OP_ADI;
        CLS_RR: begin
          unique case (sub_i)
            SUB_MOV:  op = OP_MOV;
            SUB_OR:   op = OP_OR;
            SUB_AND:  op = OP_AND;
            SUB_XOR:  op = OP_XOR;
            SUB_ADD:  op = OP_ADD;
            SUB_SUB:  op = OP_SUB;
            SUB_SHR:  op = OP_SHR;
            SUB_RSUB: op = OP_RSUB;
            SUB_SHL:  op = OP_SHL;
            default:  op = OP_NONE;
          endcase
        end
        default: op = OP_NONE;
      endcase
    end
  end

  logic is_logic;
  logic is_arith;

  assign is_logic = (op == OP_MOV) || (op == OP_OR) || (op == OP_AND) || (op == OP_XOR);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_RSUB) ||
                    (op == OP_SHR) || (op == OP_SHL);

  always_comb begin
    ctrl_o.op       = op;
    ctrl_o.res_we   = (op != OP_NONE);
    ctrl_o.flag_we  = is_arith || (is_logic && compat_i);
    ctrl_o.flag_clr = is_logic;
  end

endmodule

// File: rtl/byte_alu_datapath.sv
module byte_alu_datapath
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_ctrl_t         ctrl_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] flag_o
);

  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] sum_ab;
  logic [EXT_W-1:0] dif_ab;
  logic [EXT_W-1:0] dif_ba;
  logic [DATA_W-1:0] sum_ai;

  assign sum_ab = {1'b0, a_i} + {1'b0, b_i};
  assign dif_ab = {1'b0, a_i} - {1'b0, b_i};
  assign dif_ba = {1'b0, b_i} - {1'b0, a_i};
  assign sum_ai = a_i + imm_i;

  logic flag_bit;

  always_comb begin
    res_o    = '0;
    flag_bit = 1'b0;
    unique case (ctrl_i.op)
      OP_LDI:  res_o = imm_i;
      OP_ADI:  res_o = sum_ai;
      OP_MOV:  res_o = b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_ADD: begin
        res_o    = sum_ab[DATA_W-1:0];
        flag_bit = sum_ab[DATA_W];
      end
      OP_SUB: begin
        res_o    = dif_ab[DATA_W-1:0];
        flag_bit = ~dif_ab[DATA_W];   // not-borrow
      end
      OP_RSUB: begin
        res_o    = dif_ba[DATA_W-1:0];
        flag_bit = ~dif_ba[DATA_W];
      end
      OP_SHR: begin
        res_o    = {1'b0, a_i[DATA_W-1:1]};
        flag_bit = a_i[0];
      end
      OP_SHL: begin
        res_o    = {a_i[DATA_W-2:0], 1'b0};
        flag_bit = a_i[DATA_W-1];
      end
      default: ;
    endcase
  end

  assign flag_o = ctrl_i.flag_clr ? '0 : {{(DATA_W-1){1'b0}}, flag_bit};

endmodule

// File: rtl/byte_alu_regfile.sv
module byte_alu_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int FLAG_IX = NUM_REGS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  input  logic              res_we_i,
  input  logic [IDX_W-1:0]  res_idx_i,
  input  logic [DATA_W-1:0] res_d_i,
  input  logic              flag_we_i,
  input  logic [DATA_W-1:0] flag_d_i,
  output logic [DATA_W-1:0] flag_q_o
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  // flag port wins over result port on the flag register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (flag_we_i && (i == FLAG_IX)) begin
          regs_q[i] <= flag_d_i;
        end else if (res_we_i && (res_idx_i == IDX_W'(i))) begin
          regs_q[i] <= res_d_i;
        end
      end
    end
  end

  assign rd_a_o   = regs_q[rd_a_idx_i];
  assign rd_b_o   = regs_q[rd_b_idx_i];
  assign flag_q_o = regs_q[FLAG_IX];

endmodule

// File: rtl/byte_alu_regs.sv
module byte_alu_regs
  import byte_alu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [NIB_W-1:0]  op_class_i,
  input  logic [NIB_W-1:0]  op_sub_i,
  input  logic [IDX_W-1:0]  x_idx_i,
  input  logic [IDX_W-1:0]  y_idx_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              compat_i,
  output logic [DATA_W-1:0] x_val_o,
  output logic [DATA_W-1:0] y_val_o,
  output logic              vx_we_o,
  output logic [DATA_W-1:0] vx_wdata_o,
  output logic              vf_we_o,
  output logic [DATA_W-1:0] vf_wdata_o
);

  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] res;
  logic [DATA_W-1:0] flag;
  logic [DATA_W-1:0] flag_val;

  byte_alu_decode u_dec (
    .valid_i  (op_valid_i),
    .class_i  (op_class_i),
    .sub_i    (op_sub_i),
    .compat_i (compat_i),
    .ctrl_o   (ctrl)
  );

  byte_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl_i (ctrl),
    .a_i    (x_val_o),
    .b_i    (y_val_o),
    .imm_i  (imm_i),
    .res_o  (res),
    .flag_o (flag)
  );

  byte_alu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_idx_i (x_idx_i),
    .rd_b_idx_i (y_idx_i),
    .rd_a_o     (x_val_o),
    .rd_b_o     (y_val_o),
    .res_we_i   (ctrl.res_we),
    .res_idx_i  (x_idx_i),
    .res_d_i    (res),
    .flag_we_i  (ctrl.flag_we),
    .flag_d_i   (flag),
    .flag_q_o   (flag_val)
  );

  assign vx_we_o    = ctrl.res_we;
  assign vx_wdata_o = res;
  assign vf_we_o    = ctrl.flag_we;
  assign vf_wdata_o = flag;

endmodule

// File: rtl/byte_alu_regs_chk.sv
module byte_alu_regs_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [3:0]        op_class_i,
  input logic [3:0]        op_sub_i,
  input logic [IDX_W-1:0]  x_idx_i,
  input logic [DATA_W-1:0] imm_i,
  input logic              compat_i,
  input logic [DATA_W-1:0] x_val_o,
  input logic [DATA_W-1:0] y_val_o,
  input logic              vx_we_o,
  input logic [DATA_W-1:0] vx_wdata_o,
  input logic              vf_we_o,
  input logic [DATA_W-1:0] vf_wdata_o,
  input logic [DATA_W-1:0] flag_val
);

  localparam logic [IDX_W-1:0] FLAG_IX = IDX_W'(NUM_REGS - 1);

  logic rr;
  assign rr = op_valid_i && (op_class_i == 4'h8);

  p_load_imm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i == 4'h6) |-> (vx_we_o && vx_wdata_o == imm_i && !vf_we_o));

  p_addi_flag_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i == 4'h7 && x_idx_i != FLAG_IX) |=> $stable(flag_val));

  p_compat_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr && op_sub_i <= 4'h3 && compat_i) |-> (vf_we_o && vf_wdata_o == '0));

  p_no_compat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr && op_sub_i <= 4'h3 && !compat_i) |-> !vf_we_o);

  p_add_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr && op_sub_i == 4'h4) |->
      (vf_we_o && {vf_wdata_o[0], vx_wdata_o} == ({1'b0, x_val_o} + {1'b0, y_val_o})));

  p_sub_noborrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr && op_sub_i == 4'h5) |->
      (vf_we_o && vf_wdata_o == ((x_val_o >= y_val_o) ? DATA_W'(1) : DATA_W'(0))));

  p_rsub_noborrow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr && op_sub_i == 4'h7) |->
      (vf_we_o && vf_wdata_o == ((y_val_o >= x_val_o) ? DATA_W'(1) : DATA_W'(0))));

  p_flag_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vx_we_o && vf_we_o && x_idx_i == FLAG_IX) |=> (flag_val == $past(vf_wdata_o)));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> (!vx_we_o && !vf_we_o));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(flag_val));

endmodule

bind byte_alu_regs byte_alu_regs_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_class_i (op_class_i),
  .op_sub_i   (op_sub_i),
  .x_idx_i    (x_idx_i),
  .imm_i      (imm_i),
  .compat_i   (compat_i),
  .x_val_o    (x_val_o),
  .y_val_o    (y_val_o),
  .vx_we_o    (vx_we_o),
  .vx_wdata_o (vx_wdata_o),
  .vf_we_o    (vf_we_o),
  .vf_wdata_o (vf_wdata_o),
  .flag_val   (flag_val)
);

// File: tb/tb_byte_alu_regs.sv
`timescale 1ns/1ps
module tb_byte_alu_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_class = '0;
  logic [3:0] op_sub = '0;
  logic [3:0] x_idx = '0;
  logic [3:0] y_idx = '0;
  logic [7:0] imm = '0;
  logic       compat = 1'b0;
  logic [7:0] x_val, y_val, vx_wdata, vf_wdata;
  logic       vx_we, vf_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int model [16];

  always #4 clk = ~clk;

  byte_alu_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_class_i(op_class),
    .op_sub_i(op_sub), .x_idx_i(x_idx), .y_idx_i(y_idx), .imm_i(imm),
    .compat_i(compat), .x_val_o(x_val), .y_val_o(y_val), .vx_we_o(vx_we),
    .vx_wdata_o(vx_wdata), .vf_we_o(vf_we), .vf_wdata_o(vf_wdata)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Reference model: one operation per clock, checked mid-cycle.
  task automatic run_op(bit v, int cls, int n, int x, int y, int im, bit cm);
    int vx, vy, ed, fd, s;
    bit ew, fw;
    string tg;
    @(negedge clk);
    op_valid = v; op_class = 4'(cls); op_sub = 4'(n);
    x_idx = 4'(x); y_idx = 4'(y); imm = 8'(im); compat = cm;
    #2;
    vx = model[x]; vy = model[y];
    ew = 0; fw = 0; ed = 0; fd = 0; tg = "R11";
    if (v) begin
      if (cls == 6) begin ew = 1; ed = im; tg = "R1"; end
      else if (cls == 7) begin ew = 1; ed = (vx + im) % 256; tg = "R2"; end
      else if (cls == 8) begin
        case (n)
          0, 1, 2, 3: begin
            ew = 1; tg = cm ? "R4" : "R3";
            ed = (n == 0) ? vy : (n == 1) ? (vx | vy) : (n == 2) ? (vx & vy) : (vx ^ vy);
            fw = cm; fd = 0;
          end
          4: begin s = vx + vy; ew = 1; ed = s % 256; fw = 1; fd = (s > 255); tg = "R5"; end
          5: begin ew = 1; ed = (vx - vy + 256) % 256; fw = 1; fd = (vx >= vy); tg = "R6"; end
          7: begin ew = 1; ed = (vy - vx + 256) % 256; fw = 1; fd = (vy >= vx); tg = "R7"; end
          6: begin ew = 1; ed = vx / 2; fw = 1; fd = vx % 2; tg = "R8"; end
          14: begin ew = 1; ed = (vx * 2) % 256; fw = 1; fd = vx / 128; tg = "R8"; end
          default: ;
        endcase
      end
    end
    check({tg, " vx_we"}, int'(vx_we), int'(ew));
    if (ew) check({tg, " vx_wdata"}, int'(vx_wdata), ed);
    check({tg, " vf_we"}, int'(vf_we), int'(fw));
    if (fw) check({tg, " vf_wdata"}, int'(vf_wdata), fd);
    check("R10 x_val", int'(x_val), vx);
    check("R10 y_val", int'(y_val), vy);
    @(posedge clk); #1;
    if (ew) model[x] = ed;
    if (fw) model[15] = fd;   // R9: flag written last, wins on vF
  endtask

  task automatic idle_read(int x, string tg);
    @(negedge clk);
    op_valid = 0; x_idx = 4'(x); y_idx = 4'(15 - x);
    #2;
    check({tg, " readback x"}, int'(x_val), model[x]);
    check({tg, " readback y"}, int'(y_val), model[15 - x]);
  endtask

  task automatic sweep(string tg);
    for (int i = 0; i < 16; i++) idle_read(i, tg);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    sweep("R12");

    // R1 loads
    run_op(1, 6, 0, 1, 0, 8'hF0, 0);
    run_op(1, 6, 0, 2, 0, 8'h20, 0);
    run_op(1, 6, 0, 15, 0, 8'h5A, 0);
    // R2 wraparound add immediate, vF untouched
    run_op(1, 7, 0, 1, 0, 8'h30, 0);
    idle_read(15, "R2 vF held");
    // R5 carry
    run_op(1, 6, 0, 1, 0, 8'hFF, 0);
    run_op(1, 6, 0, 2, 0, 8'h01, 0);
    run_op(1, 8, 4, 1, 2, 0, 0);
    run_op(1, 8, 4, 1, 2, 0, 0);
    // R6 borrow / equal operands
    run_op(1, 6, 0, 3, 0, 5, 0);
    run_op(1, 6, 0, 4, 0, 7, 0);
    run_op(1, 8, 5, 3, 4, 0, 0);
    run_op(1, 8, 5, 4, 4, 0, 0);
    // R7 reversed subtract
    run_op(1, 6, 0, 3, 0, 9, 0);
    run_op(1, 8, 7, 3, 4, 0, 0);
    run_op(1, 8, 7, 4, 4, 0, 0);
    // R8 shifts with bits at both ends
    run_op(1, 6, 0, 5, 0, 8'h81, 0);
    run_op(1, 8, 6, 5, 0, 0, 0);
    run_op(1, 6, 0, 5, 0, 8'h81, 0);
    run_op(1, 8, 14, 5, 0, 0, 0);
    // R3/R4 logic ops, both modes
    run_op(1, 6, 0, 15, 0, 8'h01, 0);
    for (int k = 0; k < 4; k++) run_op(1, 8, k, 6, 1, 0, 0);
    idle_read(15, "R4 vF kept in normal mode");
    for (int k = 0; k < 4; k++) run_op(1, 8, k, 6, 1, 0, 1);
    idle_read(15, "R4 vF cleared in compat mode");
    // R9 X = F: flag beats result
    run_op(1, 6, 0, 15, 0, 8'hC8, 0);
    run_op(1, 6, 0, 7, 0, 8'h50, 0);
    run_op(1, 8, 4, 15, 7, 0, 0);
    idle_read(15, "R9 flag priority");
    run_op(1, 8, 0, 15, 7, 0, 1);
    idle_read(15, "R9 compat clear over copy");
    // R11 ignored operations
    run_op(0, 6, 0, 8, 0, 8'hEE, 0);
    run_op(1, 8, 8, 8, 1, 0, 0);
    run_op(1, 9, 0, 8, 1, 8'h11, 0);
    run_op(1, 8, 15, 15, 1, 0, 1);
    sweep("R11");

    // random mix
    for (int t = 0; t < 4000; t++) begin
      int c;
      c = $urandom_range(0, 7);
      run_op(($urandom_range(0, 9) != 0), (c < 1) ? 6 : (c < 2) ? 7 : (c < 7) ? 8 : 9,
             $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
             $urandom_range(0, 255), $urandom_range(0, 1));
    end
    sweep("R10 final");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule